// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands and returns a floating-point result rounded to nearest, with ties going to the even value. Each operand has a sign bit, a biased exponent field and a fraction field. The default widths give the 32-bit single-precision layout: bit 31 is the sign, bits 30:23 are the exponent with bias 127, and bits 22:0 are the fraction. An exponent field of zero marks a subnormal. Its value is 2^(1-bias) × 0.fraction. An all-ones exponent field encodes infinity.

The datapath first orders the operands by magnitude, with the larger one on the fixed side. It then restores the hidden bits and shifts the smaller significand right. The shift keeps guard and round bits and folds everything shifted out beyond them into a sticky bit. Next it adds or subtracts the two magnitudes. The operation select is applied by flipping the sign of B. Finally a leading-zero count renormalizes the result and adjusts the exponent, and the result is rounded. When a parameter selects it, the result passes through an output register with a synchronous reset. Infinity and NaN inputs are not handled. Results too large to represent saturate to a signed infinity.

Top module: `fp_addsub_top`

## Requirements
- R1: With OUT_REG=1, a high `rst` at a rising edge sets `res` to all zeros at that edge. Otherwise the result for the inputs present at a rising edge appears on `res` after that edge, so the latency is one cycle.
- R2: When the effective signs match, `res` is the correctly rounded sum of the two magnitudes, carrying the shared sign. Adding a zero of either sign to a nonzero finite A returns A unchanged.
- R3: `op`=1 computes A−B by adding A to B with its sign bit (the MSB) inverted. `op`=0 computes A+B.
- R4: A nonzero result takes the sign of the operand with the larger magnitude. An exact zero from an effective subtraction is +0 (all zeros). An exact zero from adding two zeros of the same sign keeps that sign. Two positive effective operands never produce a negative result.
- R5: Every bit of the smaller significand that is shifted out past the round position is ORed into the sticky bit. When the exponent difference reaches or exceeds the aligned width, the whole smaller significand collapses into the sticky bit.
- R6: Rounding is to nearest. At an exact halfway point, the result goes to the value whose lowest fraction bit is 0.
- R7: A rounding increment that carries out of the significand raises the exponent by one and clears the fraction.
- R8: Subnormal inputs take part with exponent 1 and hidden bit 0. A result below the smallest normal value is returned as a subnormal, with exponent field 0. A subnormal that rounds up to the smallest normal value gets exponent field 1.
- R9: A rounded result whose exponent would reach the all-ones field returns infinity with the result's sign: exponent all ones, fraction zero. Finite inputs never produce a NaN pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 1+EXP_W+FRAC_W | Operand A |
| b | input | 1+EXP_W+FRAC_W | Operand B |
| op | input | 1 | 0 selects A+B, 1 selects A−B |
| res | output | 1+EXP_W+FRAC_W | Rounded result |

## Verification
An 8-bit configuration (4-bit exponent, 3-bit fraction) is driven with every pair of finite operands under both operations. Each result is compared with an exact integer sum rounded in the bench. This sweep covers every alignment distance and every amount of cancellation. It also separates the halfway cases from the near-halfway cases, subnormal inputs and results from normal ones, and overflow from the largest finite value. The default 32-bit configuration gets directed cases that the small format cannot reach. These include exponent gaps far beyond the aligned width, a sticky bit that turns a tie into a round-up, a rounding carry across the binade, and overflow of either sign.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpas_op_e;
endpackage

// File: rtl/fpas_align.sv
// Orders operands by magnitude, restores hidden bits, aligns the smaller one.
module fpas_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int M     = FRAC_W + 1,
  localparam int PW    = M + 2,
  localparam int AW    = M + 3,
  localparam int SHW   = $clog2(PW + 1)
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             op,
  output logic             sign_l,
  output logic             eff_sub,
  output logic [EXP_W-1:0] exp_l,
  output logic [AW-1:0]    sig_big,
  output logic [AW-1:0]    sig_small
);
  import fpas_pkg::*;

  logic             sb_eff, a_big, sign_s;
  logic [W-2:0]     mag_l, mag_s;
  logic [EXP_W-1:0] e_l_raw, e_s_raw, e_s, diff;
  logic [M-1:0]     sig_l, sig_s;
  logic [SHW-1:0]   shamt;
  logic [2*PW-1:0]  wide;

  always_comb begin
    sb_eff  = b[W-1] ^ (op == OP_SUB);
    a_big   = (a[W-2:0] >= b[W-2:0]);
    mag_l   = a_big ? a[W-2:0] : b[W-2:0];
    mag_s   = a_big ? b[W-2:0] : a[W-2:0];
    sign_l  = a_big ? a[W-1] : sb_eff;
    sign_s  = a_big ? sb_eff : a[W-1];
    eff_sub = sign_l ^ sign_s;

    e_l_raw = mag_l[W-2:FRAC_W];
    e_s_raw = mag_s[W-2:FRAC_W];
    exp_l   = (e_l_raw == '0) ? EXP_W'(1) : e_l_raw;
    e_s     = (e_s_raw == '0) ? EXP_W'(1) : e_s_raw;
    sig_l   = {|e_l_raw, mag_l[FRAC_W-1:0]};
    sig_s   = {|e_s_raw, mag_s[FRAC_W-1:0]};

    diff    = exp_l - e_s;
    if (int'(diff) > PW) shamt = SHW'(PW);
    else                 shamt = SHW'(diff);

    wide      = {sig_s, 2'b00, {PW{1'b0}}} >> shamt;
    sig_small = {wide[2*PW-1:PW], |wide[PW-1:0]};
    sig_big   = {sig_l, 3'b000};
  end
endmodule

// File: rtl/fpas_sum.sv
// Magnitude add or subtract; the larger operand is always sig_big.
module fpas_sum #(
  parameter int AW = 27,
  localparam int SW = AW + 1
) (
  input  logic          sub,
  input  logic [AW-1:0] sig_big,
  input  logic [AW-1:0] sig_small,
  output logic [SW-1:0] sum
);
  always_comb
    sum = {1'b0, sig_big} + ({1'b0, sig_small} ^ {SW{sub}}) + SW'(sub);
endmodule

// File: rtl/fpas_lzc.sv
module fpas_lzc #(
  parameter int WIDTH = 28,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] x,
  output logic [CW-1:0]    cnt
);
  always_comb begin
    cnt = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++)
      if (x[i]) cnt = CW'(WIDTH - 1 - i);
  end
endmodule

// File: rtl/fpas_norm_round.sv
// Renormalizes the raw sum, clamps at the subnormal boundary, rounds to nearest-even.
module fpas_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int M     = FRAC_W + 1,
  localparam int SW    = M + 4,
  localparam int CW    = $clog2(SW + 1),
  localparam int EW    = ((EXP_W > CW) ? EXP_W : CW) + 2,
  localparam int MAXE  = (1 << EXP_W) - 1
) (
  input  logic [SW-1:0]    sum,
  input  logic [CW-1:0]    zlc,
  input  logic [EXP_W-1:0] exp_l,
  input  logic             sign_l,
  input  logic             eff_sub,
  output logic [W-1:0]     res
);
  logic [EW-1:0]     zx, el, lsh, exp_n, exp_f;
  logic [SW-2:0]     n;
  logic [M-1:0]      keep;
  logic              g, r, s, inc;
  logic [M:0]        rnd;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    zx = EW'(zlc);
    el = EW'(exp_l);
    if (zlc == '0) begin
      lsh   = '0;
      n     = {sum[SW-1:2], sum[1] | sum[0]};
      exp_n = el + 1'b1;
    end else begin
      lsh = zx - 1'b1;
      if (lsh >= el) lsh = el - 1'b1;
      exp_n = el - lsh;
      n     = (SW-1)'(sum << lsh);
    end

    keep = n[SW-2:3];
    g    = n[2];
    r    = n[1];
    s    = n[0];
    inc  = g & (r | s | keep[0]);
    rnd  = {1'b0, keep} + (M+1)'(inc);

    if (rnd[M]) begin
      exp_f = exp_n + 1'b1;
      frac  = '0;
    end else begin
      exp_f = rnd[M-1] ? exp_n : '0;
      frac  = rnd[FRAC_W-1:0];
    end

    if (sum == '0)
      res = {sign_l & ~eff_sub, {(W-1){1'b0}}};
    else if (exp_f >= EW'(MAXE))
      res = {sign_l, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      res = {sign_l, exp_f[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp_addsub_top.sv
module fp_addsub_top #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int M      = FRAC_W + 1,
  localparam int AW     = M + 3,
  localparam int SW     = AW + 1,
  localparam int CW     = $clog2(SW + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         op,
  output logic [W-1:0] res
);
  logic             sign_l, eff_sub;
  logic [EXP_W-1:0] exp_l;
  logic [AW-1:0]    sig_big, sig_small;
  logic [SW-1:0]    sum;
  logic [CW-1:0]    zlc;
  logic [W-1:0]     res_c;

  fpas_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) align_i (
    .a(a), .b(b), .op(op), .sign_l(sign_l), .eff_sub(eff_sub),
    .exp_l(exp_l), .sig_big(sig_big), .sig_small(sig_small)
  );

  fpas_sum #(.AW(AW)) sum_i (
    .sub(eff_sub), .sig_big(sig_big), .sig_small(sig_small), .sum(sum)
  );

  fpas_lzc #(.WIDTH(SW)) lzc_i (.x(sum), .cnt(zlc));

  fpas_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) nr_i (
    .sum(sum), .zlc(zlc), .exp_l(exp_l), .sign_l(sign_l),
    .eff_sub(eff_sub), .res(res_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= res_c;
      end
    end else begin : g_comb
      assign res = res_c;
    end
  endgenerate
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         op,
  input logic [W-1:0] res
);
  logic         seen, op_q, ok, oi;
  logic [W-1:0] a_q, b_q, ai, bi;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
    a_q  <= a;
    b_q  <= b;
    op_q <= op;
  end

  always_comb begin
    ai = OUT_REG ? a_q : a;
    bi = OUT_REG ? b_q : b;
    oi = OUT_REG ? op_q : op;
    ok = OUT_REG ? seen : 1'b1;
  end

  logic fin_a, fin_b, bs;
  assign fin_a = (ai[W-2:FRAC_W] != {EXP_W{1'b1}});
  assign fin_b = (bi[W-2:FRAC_W] != {EXP_W{1'b1}});
  assign bs    = bi[W-1] ^ oi;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    (OUT_REG && rst) |=> (res == '0));

  // R4
  a_r4_cancel_plus_zero: assert property (@(posedge clk) disable iff (rst)
    (ok && fin_a && ai[W-2:0] == bi[W-2:0] && ai[W-1] != bs) |-> (res == '0));

  // R2
  a_r2_zero_identity: assert property (@(posedge clk) disable iff (rst)
    (ok && fin_a && ai[W-2:0] != '0 && bi[W-2:0] == '0) |-> (res == ai));

  // R4
  a_r4_positive_sign: assert property (@(posedge clk) disable iff (rst)
    (ok && fin_a && fin_b && !ai[W-1] && !bs) |-> !res[W-1]);

  // R9
  a_r9_no_nan: assert property (@(posedge clk) disable iff (rst)
    (ok && fin_a && fin_b) |->
      !(res[W-2:FRAC_W] == {EXP_W{1'b1}} && res[FRAC_W-1:0] != '0));
endmodule

bind fp_addsub_top fpas_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_REG(OUT_REG)
) chk_i (
  .clk(clk), .rst(rst), .a(a), .b(b), .op(op), .res(res)
);

// File: tb/fp_addsub_top_tb_top.sv
module fp_addsub_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a_s = 8'h55, b_s = 8'h21, res_s;
  logic        op_s = 1'b0, op_w = 1'b0;
  logic [31:0] a_w = 32'h3F80_0000, b_w = 32'h4000_0000, res_w;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fp_addsub_top #(.EXP_W(4), .FRAC_W(3), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .a(a_s), .b(b_s), .op(op_s), .res(res_s));

  fp_addsub_top #(.EXP_W(8), .FRAC_W(23), .OUT_REG(1'b1)) dut_w (
    .clk(clk), .rst(rst), .a(a_w), .b(b_w), .op(op_w), .res(res_w));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Exact model of the 8-bit format: 4-bit exponent (bias 7), 3-bit fraction.
  function automatic logic [7:0] ref_small(input logic [7:0] a, input logic [7:0] b,
                                           input logic op);
    int ea, eb, xa, xb, r, mag, p, k, q, rem, half, ee;
    logic sa, sb, sg;
    sa = a[7];
    sb = b[7] ^ op;
    ea = int'(a[6:3]);
    eb = int'(b[6:3]);
    xa = ((ea != 0) ? 8 + int'(a[2:0]) : int'(a[2:0])) << ((ea == 0 ? 1 : ea) - 1);
    xb = ((eb != 0) ? 8 + int'(b[2:0]) : int'(b[2:0])) << ((eb == 0 ? 1 : eb) - 1);
    r  = (sa ? -xa : xa) + (sb ? -xb : xb);
    if (r == 0) return {sa & sb, 7'b0};
    sg  = (r < 0);
    mag = sg ? -r : r;
    p = 0;
    for (int i = 0; i < 31; i++) if ((mag >> i) & 1) p = i;
    k = (p > 3) ? p - 3 : 0;
    q = mag >> k;
    if (k > 0) begin
      rem  = mag & ((1 << k) - 1);
      half = 1 << (k - 1);
      if (rem > half || (rem == half && (q & 1) == 1)) q++;
      if (q == 16) begin q = 8; k++; end
    end
    ee = k + 1;
    if (q < 8) return {sg, 4'b0, 3'(q)};
    if (ee >= 15) return {sg, 4'hF, 3'b0};
    return {sg, 4'(ee), 3'(q - 8)};
  endfunction

  task automatic wcase(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic op, input logic [31:0] exp);
    @(negedge clk);
    a_w = a; b_w = b; op_w = op;
    @(posedge clk);
    #1;
    chk(tag, res_w, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset small", {24'b0, res_s}, 32'h0);
    chk("R1 reset wide", res_w, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    wcase("R2 1+2", 32'h3F80_0000, 32'h4000_0000, 1'b0, 32'h4040_0000);
    wcase("R2 x+(-0)", 32'h4049_0FDB, 32'h8000_0000, 1'b0, 32'h4049_0FDB);
    wcase("R3 3-1", 32'h4040_0000, 32'h3F80_0000, 1'b1, 32'h4000_0000);
    wcase("R4 cancel", 32'h3FC0_0000, 32'h3FC0_0000, 1'b1, 32'h0000_0000);
    wcase("R4 -1+0.5", 32'hBF80_0000, 32'h3F00_0000, 1'b0, 32'hBF00_0000);
    wcase("R4 -0+-0", 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000);
    wcase("R5 far add", 32'h3F80_0000, 32'h3080_0000, 1'b0, 32'h3F80_0000);
    wcase("R5 far sub", 32'h3F80_0000, 32'h3080_0000, 1'b1, 32'h3F80_0000);
    wcase("R5 sticky breaks tie", 32'h3F80_0000, 32'h3380_0001, 1'b0, 32'h3F80_0001);
    wcase("R6 tie to even down", 32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000);
    wcase("R6 tie to even up", 32'h3F80_0001, 32'h3380_0000, 1'b0, 32'h3F80_0002);
    wcase("R7 round carry", 32'h3FFF_FFFF, 32'h3380_0000, 1'b0, 32'h4000_0000);
    wcase("R8 subnormal add", 32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0000_0002);
    wcase("R8 into subnormal", 32'h0080_0000, 32'h0000_0001, 1'b1, 32'h007F_FFFF);
    wcase("R8 subnormal to normal", 32'h007F_FFFF, 32'h0000_0001, 1'b0, 32'h0080_0000);
    wcase("R9 overflow pos", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000);
    wcase("R9 overflow neg", 32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, 32'hFF80_0000);

    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        for (int io = 0; io < 2; io++) begin
          logic [7:0] av, bv, ex;
          string tag;
          av = 8'(ia);
          bv = 8'(ib);
          if (av[6:3] == 4'hF || bv[6:3] == 4'hF) continue;
          ex = ref_small(av, bv, io[0]);
          if (ex[6:3] == 4'hF)                               tag = "R9 sweep";
          else if (ex[6:0] == 7'b0)                          tag = "R4 sweep";
          else if (av[6:3] == 0 || bv[6:3] == 0 || ex[6:3] == 0) tag = "R8 sweep";
          else if (io != 0)                                  tag = "R3 sweep";
          else                                               tag = "R2 sweep";
          @(negedge clk);
          a_s = av; b_s = bv; op_s = io[0];
          @(posedge clk);
          #1;
          chk(tag, {24'b0, res_s}, {24'b0, ex});
        end
      end
    end
    finish_run();
  end
endmodule